// File: doc/BRIEF.md
# Operand Register Bank with Constant Source

This block holds the sixteen architectural registers of a small 16-bit processor core. It has two combinational read ports. The source port serves the first operand and the destination port serves the second. One synchronous write port takes the execution result and can write a whole word or only the low byte. Register 0 is the program counter and register 1 is the stack pointer. Neither can hold an odd value. Register 2 is the status register, and register 3 holds no state.

The source port also takes the operand's 2-bit addressing mode. When the source is register 2 or register 3 in certain modes, the port returns a fixed constant in place of the register contents and raises a flag. The decode stage can then use a common value without fetching an immediate word. For every source register and mode, the port also reports whether the operand needs an extension word that follows the instruction.

Top module: `opnd_regbank`

## Requirements
- R1: Both read ports are combinational. A write on a clock edge is visible on both ports from that edge on. Before the edge, the ports show the old contents.
- R2: A word write (`wr_byte`=0) stores all 16 bits of `wr_data` into R2 or R4 to R15.
- R3: A byte write (`wr_byte`=1) stores `wr_data[7:0]` in bits 7:0 of the register and clears bits 15:8 to zero.
- R4: Any write to R0 or R1, word or byte, stores bit 0 as zero. Read back through the destination port, these registers never show an odd value.
- R5: Writes to R3 are ignored. R3 read through the destination port is always 0.
- R6: A source read of R3 raises `src_is_const` and returns a constant chosen by the mode: 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 0xFFFF.
- R7: A source read of R2 in mode 10 returns 4, and in mode 11 returns 8, with `src_is_const` high. In mode 00 it returns the status register contents with `src_is_const` low.
- R8: A source read of R2 in mode 01 returns 0, which serves as the zero base of an absolute address. `src_is_const` is low in this case.
- R9: `src_ext_word` is high exactly when the mode is 01 and the register is not R3, or when the mode is 11 and the register is R0. In every other case it is low.
- R10: A synchronous active-low reset (`rst_n`=0 at a clock edge) clears every register to zero.
- R11: A source read of R0, R1 or R4 to R15 returns the register contents in every mode, with `src_is_const` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 4 | Source register index |
| src_mode | input | 2 | Source addressing mode |
| src_data | output | 16 | Source operand value or constant |
| src_is_const | output | 1 | A constant replaced the register read |
| src_ext_word | output | 1 | Source operand needs an extension word |
| dst_sel | input | 4 | Destination register index |
| dst_data | output | 16 | Destination register contents |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register index |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write value |

## Verification
The bench builds the block with its default parameters, 16-bit data and sixteen registers. With these defaults the 4-bit selects reach every register, including the two special registers below the constant source. The all-ones constant and the cleared upper byte can then be checked at their real widths. The bench walks all 64 pairs of source register and mode, and checks the flags and value of each pair. It then mixes random writes and reads with directed odd writes to the program counter and the stack pointer.

// File: rtl/rb_pkg.sv
// Package: shared constants and types for the operand register bank.
// Assumes register indices 0..3 carry the fixed roles listed here.
package rb_pkg;
    localparam int RB_PC = 0;
    localparam int RB_SP = 1;
    localparam int RB_SR = 2;
    localparam int RB_CG = 3;

    typedef enum logic [1:0] {
        AM_REG = 2'b00,
        AM_IDX = 2'b01,
        AM_IND = 2'b10,
        AM_INC = 2'b11
    } amode_e;
endpackage

// File: rtl/rb_storage.sv
// Module: register storage with write shaping.
// It holds NUM_REGS registers of DATA_W bits each, presented as one flat vector.
// A byte write zero-extends the low byte. The PC and SP slots clear bit 0 on every write.
// The constant slot holds no flop and reads as zero.
// Assumes DATA_W >= 16 and NUM_REGS >= 4. The reset is synchronous and active low.
module rb_storage #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_sel,
    input  logic                       wr_byte,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    import rb_pkg::*;

    logic [DATA_W-1:0] shaped;

    // Shape the incoming value: on a byte write, keep the low byte and clear the rest.
    always_comb begin
        shaped = wr_data;
        if (wr_byte) begin
            shaped = '0;
            shaped[7:0] = wr_data[7:0];
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == RB_CG) begin : g_const_slot
            // The constant slot has no storage and always reads as zero.
            assign regs_flat[i*DATA_W +: DATA_W] = '0;
        end else if (i == RB_PC || i == RB_SP) begin : g_even_slot
            logic [DATA_W-1:0] q;
            // Hold the PC or SP, with bit 0 forced low on every write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && int'(wr_sel) == i)
                    q <= {shaped[DATA_W-1:1], 1'b0};
            end
            assign regs_flat[i*DATA_W +: DATA_W] = q;
        end else begin : g_plain_slot
            logic [DATA_W-1:0] q;
            // Hold a plain register (the status register or a general-purpose one).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && int'(wr_sel) == i)
                    q <= shaped;
            end
            assign regs_flat[i*DATA_W +: DATA_W] = q;
        end
    end
endmodule

// File: rtl/rb_read_port.sv
// Module: one combinational read port.
// It selects a DATA_W slice from the flat register vector.
// Assumes sel < NUM_REGS.
module rb_read_port #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
    input  logic [ADDR_W-1:0]          sel,
    output logic [DATA_W-1:0]          data
);
    // Pick the addressed register.
    always_comb begin
        data = regs_flat[int'(sel)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/rb_const_gen.sv
// Module: source-operand constant decode.
// From the source register index and its 2-bit mode it produces four outputs:
// the constant, a flag for a constant substitution, a flag for the absolute-address
// zero base, and a flag for an extension word.
// Assumes the register roles defined in rb_pkg.
module rb_const_gen #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] sel,
    input  logic [1:0]        mode,
    output logic              is_const,
    output logic              zero_base,
    output logic              ext_word,
    output logic [DATA_W-1:0] const_val
);
    import rb_pkg::*;

    amode_e am;
    logic   is_sr;
    logic   is_cg;
    logic   is_pc;

    // Classify the source register and mode.
    always_comb begin
        am    = amode_e'(mode);
        is_sr = (int'(sel) == RB_SR);
        is_cg = (int'(sel) == RB_CG);
        is_pc = (int'(sel) == RB_PC);
    end

    // Choose the constant and set the substitution flags.
    always_comb begin
        is_const  = 1'b0;
        zero_base = 1'b0;
        const_val = '0;
        if (is_cg) begin
            is_const = 1'b1;
            unique case (am)
                AM_REG: const_val = '0;
                AM_IDX: const_val = DATA_W'(1);
                AM_IND: const_val = DATA_W'(2);
                AM_INC: const_val = '1;
            endcase
        end else if (is_sr) begin
            unique case (am)
                AM_REG: ;
                AM_IDX: zero_base = 1'b1;
                AM_IND: begin
                    is_const  = 1'b1;
                    const_val = DATA_W'(4);
                end
                AM_INC: begin
                    is_const  = 1'b1;
                    const_val = DATA_W'(8);
                end
            endcase
        end
    end

    // Flag operands that need a word after the instruction: indexed, absolute or immediate.
    always_comb begin
        ext_word = ((am == AM_IDX) && !is_cg) || ((am == AM_INC) && is_pc);
    end
endmodule

// File: rtl/opnd_regbank.sv
// Module: top of the operand register bank.
// It has a source read port with constant substitution, a plain destination read port,
// and one synchronous write port with a byte/word select.
// Assumes DATA_W >= 16 and NUM_REGS >= 4. The reset is synchronous and active low.
module opnd_regbank #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] src_sel,
    input  logic [1:0]        src_mode,
    output logic [DATA_W-1:0] src_data,
    output logic              src_is_const,
    output logic              src_ext_word,
    input  logic [ADDR_W-1:0] dst_sel,
    output logic [DATA_W-1:0] dst_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data
);
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]          src_raw;
    logic [DATA_W-1:0]          const_val;
    logic                       zero_base;

    rb_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_byte   (wr_byte),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    rb_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_src_rd (
        .regs_flat (regs_flat),
        .sel       (src_sel),
        .data      (src_raw)
    );

    rb_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dst_rd (
        .regs_flat (regs_flat),
        .sel       (dst_sel),
        .data      (dst_data)
    );

    rb_const_gen #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_cgen (
        .sel       (src_sel),
        .mode      (src_mode),
        .is_const  (src_is_const),
        .zero_base (zero_base),
        .ext_word  (src_ext_word),
        .const_val (const_val)
    );

    // Merge the source port: a constant, the zero base, or the register contents.
    always_comb begin
        if (src_is_const)
            src_data = const_val;
        else if (zero_base)
            src_data = '0;
        else
            src_data = src_raw;
    end
endmodule

// File: rtl/opnd_regbank_chk.sv
// Module: assertion checker for opnd_regbank, attached with bind.
// Assumes the same parameters as the top module.
module opnd_regbank_chk #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] src_sel,
    input logic [DATA_W-1:0] src_data,
    input logic              src_is_const,
    input logic              src_ext_word,
    input logic [ADDR_W-1:0] dst_sel,
    input logic [DATA_W-1:0] dst_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_sel,
    input logic              wr_byte,
    input logic [DATA_W-1:0] wr_data
);
    // R2
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte && wr_sel == dst_sel && int'(wr_sel) >= 4)
        |=> (!$stable(dst_sel) || dst_data == $past(wr_data)));

    // R3
    byte_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_sel == dst_sel && int'(wr_sel) != 3)
        |=> (!$stable(dst_sel) || dst_data[DATA_W-1:8] == '0));

    // R4
    even_pc_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(dst_sel) < 2) |-> (dst_data[0] == 1'b0));

    // R5
    cg_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(dst_sel) == 3) |-> (dst_data == '0));

    // R6
    cg_is_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_sel) == 3) |-> (src_is_const && !src_ext_word));

    // R11
    ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_is_const && int'(src_sel) != 2 && src_sel == dst_sel) |-> (src_data == dst_data));
endmodule

bind opnd_regbank opnd_regbank_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_sel      (src_sel),
    .src_data     (src_data),
    .src_is_const (src_is_const),
    .src_ext_word (src_ext_word),
    .dst_sel      (dst_sel),
    .dst_data     (dst_data),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_byte      (wr_byte),
    .wr_data      (wr_data)
);

// File: tb/opnd_regbank_tb_top.sv
`timescale 1ns/1ps
// Bench: random and directed tests of opnd_regbank against a reference model.
module opnd_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_sel = '0;
    logic [1:0]  src_mode = '0;
    logic [15:0] src_data;
    logic        src_is_const;
    logic        src_ext_word;
    logic [3:0]  dst_sel = '0;
    logic [15:0] dst_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic        wr_byte = 1'b0;
    logic [15:0] wr_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] model [16];

    opnd_regbank dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_sel(src_sel), .src_mode(src_mode), .src_data(src_data),
        .src_is_const(src_is_const), .src_ext_word(src_ext_word),
        .dst_sel(dst_sel), .dst_data(dst_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_src(input logic [3:0] s, input logic [1:0] m);
        if (s == 4'd3) begin
            case (m)
                2'd0: return 16'h0000;
                2'd1: return 16'h0001;
                2'd2: return 16'h0002;
                default: return 16'hFFFF;
            endcase
        end
        if (s == 4'd2) begin
            case (m)
                2'd0: return model[2];
                2'd1: return 16'h0000;
                2'd2: return 16'h0004;
                default: return 16'h0008;
            endcase
        end
        return model[s];
    endfunction

    function automatic logic exp_const(input logic [3:0] s, input logic [1:0] m);
        return (s == 4'd3) || (s == 4'd2 && m[1]);
    endfunction

    function automatic logic exp_ext(input logic [3:0] s, input logic [1:0] m);
        return (m == 2'd1 && s != 4'd3) || (m == 2'd3 && s == 4'd0);
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Write one register and update the model once the edge has passed.
    task automatic wr(input logic [3:0] s, input logic b, input logic [15:0] d);
        logic [15:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_byte = b; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        v = b ? {8'h00, d[7:0]} : d;
        if (s < 4'd2) v[0] = 1'b0;
        if (s != 4'd3) model[s] = v;
    endtask

    // Read both ports and compare them with the model.
    task automatic rd(input logic [3:0] s, input logic [1:0] m, input logic [3:0] d, input string req);
        @(negedge clk);
        src_sel = s; src_mode = m; dst_sel = d;
        #1;
        check(req, "src_data", src_data, exp_src(s, m));
        check(req, "src_is_const", {15'd0, src_is_const}, {15'd0, exp_const(s, m)});
        check("R9", "src_ext_word", {15'd0, src_ext_word}, {15'd0, exp_ext(s, m)});
        check(req, "dst_data", dst_data, model[d]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state of every register
        for (int i = 0; i < 16; i++) rd(4'(i), 2'd0, 4'(i), "R10");

        // R2, R1: word writes, visible after the edge
        wr(4'd7, 1'b0, 16'hBEEF); rd(4'd7, 2'd0, 4'd7, "R2");
        wr(4'd2, 1'b0, 16'h0107); rd(4'd2, 2'd0, 4'd2, "R7");
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd9; wr_byte = 1'b0; wr_data = 16'h5A5A; dst_sel = 4'd9;
        #1 check("R1", "before edge", dst_data, model[9]);
        @(negedge clk); wr_en = 1'b0; model[9] = 16'h5A5A;
        #1 check("R1", "after edge", dst_data, 16'h5A5A);

        // R3: byte write clears the high byte
        wr(4'd5, 1'b0, 16'h1234); wr(4'd5, 1'b1, 16'hABCD);
        rd(4'd5, 2'd2, 4'd5, "R3");
        check("R3", "byte result", dst_data, 16'h00CD);

        // R4: odd values to PC and SP
        wr(4'd0, 1'b0, 16'hFFFF); rd(4'd0, 2'd0, 4'd0, "R4");
        check("R4", "pc even", dst_data, 16'hFFFE);
        wr(4'd1, 1'b1, 16'h3333); rd(4'd1, 2'd2, 4'd1, "R4");
        check("R4", "sp even", dst_data, 16'h0032);
        wr(4'd1, 1'b0, 16'h8001); rd(4'd1, 2'd3, 4'd1, "R4");

        // R5: write to the constant slot is ignored
        wr(4'd3, 1'b0, 16'h7777); rd(4'd3, 2'd0, 4'd3, "R5");
        check("R5", "cg dst", dst_data, 16'h0000);

        // R6, R7, R8, R9, R11: every register and mode pair
        for (int s = 0; s < 16; s++)
            for (int m = 0; m < 4; m++)
                rd(4'(s), 2'(m), 4'(s),
                   s == 3 ? "R6" : (s == 2 ? (m == 1 ? "R8" : "R7") : "R11"));

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            wr(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 16'($urandom));
            rd(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), "R11");
        end

        // R10: reset clears everything again
        wr(4'd12, 1'b0, 16'hC0DE);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) model[i] = 16'h0000;
        for (int i = 0; i < 16; i++) begin
            dst_sel = 4'(i); #1;
            check("R10", "after reset", dst_data, 16'h0000);
        end
        @(negedge clk); rst_n = 1'b1;
        rd(4'd12, 2'd0, 4'd12, "R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule